// File: doc/BRIEF.md
# CRC-4 Protected Card Command Framer

This block prepares the bit strings a reader sends to a small contactless memory card and checks the integrity of the card's answers. A request names a card type code, an address and an operation. The type code fixes how many address bits the card understands. The block builds the command word from the address and a one-bit operation selector. It then runs a bit-serial 4-bit CRC over the command together with a data byte.

For a write, the data byte is the byte to store. The block returns the full outgoing frame: command, then data, then CRC, with its length in bits. For a read, the data byte is the low byte of the 12-bit response already captured from the card. The block returns the command word and its length, the received byte, and a flag that is set when the received CRC nibble disagrees with the one it computed.

Requests with an unknown card type, and writes to the protected low addresses, complete at once with an error flag. The radio link, its timing and any scrambling are outside the block.

Top module: `card_cmd_framer`

## Requirements
- R1: Card type code 0x0D selects 5 address bits (6-bit command), code 0x1D selects 8 address bits (9-bit command), and code 0x3D selects 10 address bits (11-bit command).
- R2: Any other card type code completes with `type_err`=1, `addr_err`=0, `crc_err`=0, and `cmd_word`, `cmd_len` and `rd_byte` all 0. `done` is visible right after the accepting clock edge, and `busy` stays 0.
- R3: The command is the address masked to the card's address bits, shifted left by one, with bit 0 set to the selector (1 for read, 0 for write). Address bits above the card's width have no effect.
- R4: The CRC starts at 0x5. Its input is the value (data << cmd_bits) | command, taken over 8 + cmd_bits bits, least significant bit first. For each input bit b: fb = crc[0] ^ b, then crc = (crc >> 1) ^ (fb ? 0xC : 0). No final XOR is applied.
- R5: A read returns `cmd_word` = command, `cmd_len` = command bits and `rd_byte` = rx_frame[7:0]. The CRC is computed with rx_frame[7:0] as the data byte. `crc_err` is 1 exactly when that CRC differs from rx_frame[11:8].
- R6: A write returns `cmd_word` = command | data << (abits+1) | crc << (abits+9), and `cmd_len` = abits + 13, with `crc_err`=0 and `rd_byte`=0.
- R7: A write whose masked address is 0 to 4 is refused. It completes with `addr_err`=1 and all other outputs 0, with `done` visible right after the accepting edge. A write to address 5 is accepted.
- R8: An accepted valid request raises `busy` after the accepting edge. `done` is a one-cycle pulse seen 9 + cmd_bits clock edges after the accepting edge, and `busy` drops together with it.
- R9: `start` is ignored while `busy` is 1. All request inputs are sampled only at the accepting edge, so later changes leave the result unchanged and no second completion follows.
- R10: After reset, `busy`, `done`, all flags, `cmd_word`, `cmd_len` and `rd_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op_write | input | 1 | 1 = write request, 0 = read request |
| card_type | input | 8 | Detected card type code |
| addr | input | 10 | Byte address on the card |
| wr_data | input | 8 | Byte to write |
| rx_frame | input | 12 | Card response: CRC in 11:8, data in 7:0 |
| busy | output | 1 | CRC computation in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_word | output | 23 | Command word (read) or full frame (write) |
| cmd_len | output | 5 | Valid bits in cmd_word |
| rd_byte | output | 8 | Received data byte of a read |
| crc_err | output | 1 | Read response CRC mismatch |
| type_err | output | 1 | Unknown card type |
| addr_err | output | 1 | Write to a protected address refused |

## Verification
The bench sweeps every address of the two smaller card types, and a strided set of addresses of the largest, for both operations. It pairs each read with a correct and with a corrupted CRC nibble, so a wrong polynomial, initial value, bit order or data placement shows up as a mismatched frame or a wrong `crc_err`. It probes the write-protection boundary at 4 and 5, and it uses addresses with high bits set on small cards. A design that skipped masking would there emit wider commands or refuse the wrong writes. It also fires `start` and changes inputs mid-operation, so a design that re-armed or re-sampled would produce a second `done` or a different frame. Each completion's latency is measured, so an off-by-one in the bit counter is caught.

// File: rtl/ccf_pkg.sv
// Package: card type codes shared by the framer's decode logic.
// Assumes the three supported card families are identified by 8-bit codes.
package ccf_pkg;
    localparam logic [7:0] CT_SMALL  = 8'h0D;
    localparam logic [7:0] CT_MEDIUM = 8'h1D;
    localparam logic [7:0] CT_LARGE  = 8'h3D;

    localparam int ABITS_SMALL  = 5;
    localparam int ABITS_MEDIUM = 8;
    localparam int ABITS_LARGE  = 10;
endpackage

// File: rtl/ccf_type_decode.sv
// Module: maps a card type code to the number of address bits it uses.
// Assumes LEN_W can hold the largest address width; unknown codes give valid=0.
module ccf_type_decode #(
    parameter int LEN_W = 5
) (
    input  logic [7:0]       card_type,
    output logic             valid,
    output logic [LEN_W-1:0] abits
);
    import ccf_pkg::*;

    // Pick the address width for the known codes, flag everything else.
    always_comb begin
        valid = 1'b1;
        abits = '0;
        case (card_type)
            CT_SMALL:  abits = LEN_W'(ABITS_SMALL);
            CT_MEDIUM: abits = LEN_W'(ABITS_MEDIUM);
            CT_LARGE:  abits = LEN_W'(ABITS_LARGE);
            default:   valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ccf_crc_serial.sv
// Module: bit-serial CRC over a loaded word, least significant bit first.
// Assumes nbits >= 1 and that start is only raised while not busy.
// One input bit is consumed per clock; done pulses once after the last bit.
module ccf_crc_serial #(
    parameter int                WORD_W   = 19,
    parameter int                CNT_W    = 5,
    parameter int                CRC_W    = 4,
    parameter logic [CRC_W-1:0]  CRC_POLY = 4'hC,
    parameter logic [CRC_W-1:0]  CRC_INIT = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbits,
    output logic              busy,
    output logic              done,
    output logic [CRC_W-1:0]  crc
);
    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CRC_W-1:0]  crc_nxt;
    logic              fb;

    // One shift step of the reflected CRC register.
    always_comb begin
        fb      = crc[0] ^ sr_q[0];
        crc_nxt = (crc >> 1) ^ (fb ? CRC_POLY : '0);
    end

    // Load on start, then consume one bit per cycle until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            crc   <= '0;
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sr_q  <= word;
                cnt_q <= nbits;
                crc   <= CRC_INIT;
                busy  <= 1'b1;
            end else if (busy) begin
                crc   <= crc_nxt;
                sr_q  <= sr_q >> 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/card_cmd_framer.sv
// Module: builds card read/write command frames and checks read response CRCs.
// Assumes ADDR_W covers the largest card (10 bits) and an 8-bit data byte.
// Unknown card types and writes to protected low addresses complete at once.
module card_cmd_framer #(
    parameter int                ADDR_W    = 10,
    parameter int                DATA_W    = 8,
    parameter int                CRC_W     = 4,
    parameter logic [CRC_W-1:0]  CRC_POLY  = 4'hC,
    parameter logic [CRC_W-1:0]  CRC_INIT  = 4'h5,
    parameter int                PROT_LAST = 4,
    localparam int CMD_W   = ADDR_W + 1,
    localparam int WORD_W  = DATA_W + CMD_W,
    localparam int FRAME_W = CMD_W + DATA_W + CRC_W,
    localparam int RESP_W  = DATA_W + CRC_W,
    localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op_write,
    input  logic [7:0]         card_type,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [RESP_W-1:0]  rx_frame,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] cmd_word,
    output logic [LEN_W-1:0]   cmd_len,
    output logic [DATA_W-1:0]  rd_byte,
    output logic               crc_err,
    output logic               type_err,
    output logic               addr_err
);
    logic              dec_valid;
    logic [LEN_W-1:0]  dec_abits;
    logic [LEN_W-1:0]  dec_cbits;
    logic [ADDR_W-1:0] addr_mask;
    logic [ADDR_W-1:0] addr_m;
    logic [CMD_W-1:0]  cmd_new;
    logic [DATA_W-1:0] data_sel;
    logic [WORD_W-1:0] word_new;
    logic [LEN_W-1:0]  eng_bits;
    logic              accept, refuse_wr, eng_start;
    logic              eng_busy, eng_done;
    logic [CRC_W-1:0]  eng_crc;

    logic              op_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [LEN_W-1:0]  abits_q;
    logic [DATA_W-1:0] data_q;
    logic [RESP_W-1:0] rx_q;

    ccf_type_decode #(.LEN_W(LEN_W)) u_dec (
        .card_type (card_type),
        .valid     (dec_valid),
        .abits     (dec_abits)
    );

    // Form the command and the CRC input word from the live request inputs.
    always_comb begin
        dec_cbits = dec_abits + 1'b1;
        addr_mask = ~({ADDR_W{1'b1}} << dec_abits);
        addr_m    = addr & addr_mask;
        cmd_new   = {addr_m, ~op_write};
        data_sel  = op_write ? wr_data : rx_frame[DATA_W-1:0];
        word_new  = (WORD_W'(data_sel) << dec_cbits) | WORD_W'(cmd_new);
        eng_bits  = LEN_W'(DATA_W) + dec_cbits;
        accept    = start && !busy;
        refuse_wr = op_write && (addr_m <= ADDR_W'(PROT_LAST));
        eng_start = accept && dec_valid && !refuse_wr;
    end

    ccf_crc_serial #(
        .WORD_W   (WORD_W),
        .CNT_W    (LEN_W),
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY),
        .CRC_INIT (CRC_INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .word  (word_new),
        .nbits (eng_bits),
        .busy  (eng_busy),
        .done  (eng_done),
        .crc   (eng_crc)
    );

    // Request control: accept, reject early, or collect the CRC and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cmd_word <= '0;
            cmd_len  <= '0;
            rd_byte  <= '0;
            crc_err  <= 1'b0;
            type_err <= 1'b0;
            addr_err <= 1'b0;
            op_q     <= 1'b0;
            cmd_q    <= '0;
            abits_q  <= '0;
            data_q   <= '0;
            rx_q     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (!dec_valid || refuse_wr) begin
                    done     <= 1'b1;
                    type_err <= !dec_valid;
                    addr_err <= dec_valid;
                    crc_err  <= 1'b0;
                    cmd_word <= '0;
                    cmd_len  <= '0;
                    rd_byte  <= '0;
                end else begin
                    busy    <= 1'b1;
                    op_q    <= op_write;
                    cmd_q   <= cmd_new;
                    abits_q <= dec_abits;
                    data_q  <= wr_data;
                    rx_q    <= rx_frame;
                end
            end else if (eng_done) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                type_err <= 1'b0;
                addr_err <= 1'b0;
                if (op_q) begin
                    cmd_word <= FRAME_W'(cmd_q)
                              | (FRAME_W'(data_q) << (abits_q + 1'b1))
                              | (FRAME_W'(eng_crc) << (abits_q + LEN_W'(DATA_W + 1)));
                    cmd_len  <= abits_q + LEN_W'(DATA_W + CRC_W + 1);
                    rd_byte  <= '0;
                    crc_err  <= 1'b0;
                end else begin
                    cmd_word <= FRAME_W'(cmd_q);
                    cmd_len  <= abits_q + 1'b1;
                    rd_byte  <= rx_q[DATA_W-1:0];
                    crc_err  <= (eng_crc != rx_q[RESP_W-1:DATA_W]);
                end
            end
        end
    end

    // R8
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R8
    busy_tracks_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> busy);

    // R9
    accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy || done));

    // R2
    type_err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && type_err) |-> (cmd_len == '0 && cmd_word == '0 && rd_byte == '0));

    // R5
    single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({type_err, addr_err, crc_err}));

    // R6
    write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !type_err && !addr_err && op_q)
            |-> (cmd_len == abits_q + LEN_W'(DATA_W + CRC_W + 1)));
endmodule

// File: tb/card_cmd_framer_tb.sv
module card_cmd_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_write = 1'b0;
    logic [7:0]  card_type = 8'h00;
    logic [9:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] rx_frame = '0;
    logic        busy, done, crc_err, type_err, addr_err;
    logic [22:0] cmd_word;
    logic [4:0]  cmd_len;
    logic [7:0]  rd_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    card_cmd_framer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
        .card_type(card_type), .addr(addr), .wr_data(wr_data), .rx_frame(rx_frame),
        .busy(busy), .done(done), .cmd_word(cmd_word), .cmd_len(cmd_len),
        .rd_byte(rd_byte), .crc_err(crc_err), .type_err(type_err), .addr_err(addr_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] crc_model(input logic [18:0] w, input int n);
        logic [3:0] c = 4'h5;
        for (int i = 0; i < n; i++) begin
            logic fb = c[0] ^ w[i];
            c = (c >> 1) ^ (fb ? 4'hC : 4'h0);
        end
        return c;
    endfunction

    function automatic int abits_of(input logic [7:0] t);
        case (t)
            8'h0D: return 5;
            8'h1D: return 8;
            8'h3D: return 10;
            default: return -1;
        endcase
    endfunction

    // Compute the expected outcome of a request from the requirements.
    task automatic expect_of(input logic [7:0] t, input bit w, input logic [9:0] a,
                             input logic [7:0] d, input logic [11:0] rx,
                             output int lat, output logic [22:0] ew, output int el,
                             output logic [7:0] eb, output bit ec, output bit et, output bit ea);
        int ab = abits_of(t);
        lat = 0; ew = '0; el = 0; eb = '0; ec = 0; et = 0; ea = 0;
        if (ab < 0) begin
            et = 1;
        end else begin
            logic [9:0]  am = a & 10'((1 << ab) - 1);
            logic [10:0] cmd = {am, ~w};
            logic [7:0]  dd = w ? d : rx[7:0];
            logic [18:0] word = (19'(dd) << (ab + 1)) | 19'(cmd);
            logic [3:0]  c = crc_model(word, ab + 9);
            if (w && am <= 4) begin
                ea = 1;
            end else begin
                lat = ab + 10;
                if (w) begin
                    ew = 23'(cmd) | (23'(d) << (ab + 1)) | (23'(c) << (ab + 9));
                    el = ab + 13;
                end else begin
                    ew = 23'(cmd);
                    el = ab + 1;
                    eb = rx[7:0];
                    ec = (c != rx[11:8]);
                end
            end
        end
    endtask

    // Issue a request and compare the completion against the model.
    task automatic run_op(input logic [7:0] t, input bit w, input logic [9:0] a,
                          input logic [7:0] d, input logic [11:0] rx, input string tag);
        int elat, el, lat;
        logic [22:0] ew;
        logic [7:0] eb;
        bit ec, et, ea, b0;
        expect_of(t, w, a, d, rx, elat, ew, el, eb, ec, et, ea);
        card_type = t; op_write = w; addr = a; wr_data = d; rx_frame = rx; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        b0 = busy;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk); #1;
            lat++;
        end
        chk(b0 == (elat != 0), {tag, " R8 busy after accept"}, b0, elat != 0);
        chk(lat == elat, {tag, " R8 latency"}, lat, elat);
        chk(cmd_word == ew, {tag, " R3 cmd_word"}, cmd_word, ew);
        chk(cmd_len == 5'(el), {tag, " R1 cmd_len"}, cmd_len, el);
        chk(rd_byte == eb, {tag, " R5 rd_byte"}, rd_byte, eb);
        chk(crc_err == ec, {tag, " R4 crc_err"}, crc_err, ec);
        chk(type_err == et, {tag, " R2 type_err"}, type_err, et);
        chk(addr_err == ea, {tag, " R7 addr_err"}, addr_err, ea);
        @(posedge clk); #1;
        chk(!done, {tag, " R8 single pulse"}, done, 0);
    endtask

    function automatic logic [11:0] good_rx(input logic [7:0] t, input logic [9:0] a,
                                            input logic [7:0] d, input bit corrupt);
        int ab = abits_of(t);
        logic [9:0] am = a & 10'((1 << ab) - 1);
        logic [18:0] word = (19'(d) << (ab + 1)) | 19'({am, 1'b1});
        logic [3:0] c = crc_model(word, ab + 9);
        return {c ^ (corrupt ? 4'(1 + (a % 15)) : 4'h0), d};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(!busy && !done, "R10 busy/done", {busy, done}, 0);
        chk(cmd_word == 0 && cmd_len == 0 && rd_byte == 0, "R10 outputs", cmd_word, 0);
        chk(!crc_err && !type_err && !addr_err, "R10 flags", {crc_err, type_err, addr_err}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 R3 R5 R6 R7: full sweep of the small card, both operations
        for (int a = 0; a < 32; a++) begin
            logic [7:0] d = 8'((a * 37 + 5) & 8'hFF);
            run_op(8'h0D, 1'b0, 10'(a), 8'h00, good_rx(8'h0D, 10'(a), d, a[0]), "small rd");
            run_op(8'h0D, 1'b1, 10'(a), d, 12'h000, "small wr");
        end
        // R1 R4 R5 R6: medium card, every address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d = 8'((a * 101 + 3) & 8'hFF);
            run_op(8'h1D, 1'b0, 10'(a), 8'h00, good_rx(8'h1D, 10'(a), d, (a % 3) == 0), "med rd");
            run_op(8'h1D, 1'b1, 10'(a), d, 12'h000, "med wr");
        end
        // R1 R6: large card, strided addresses including the top
        for (int a = 0; a < 1024; a += 5) begin
            logic [7:0] d = 8'((a * 13 + 77) & 8'hFF);
            run_op(8'h3D, 1'b0, 10'(a), 8'h00, good_rx(8'h3D, 10'(a), d, a[1]), "lg rd");
            run_op(8'h3D, 1'b1, 10'(a), d, 12'h000, "lg wr");
        end
        run_op(8'h3D, 1'b1, 10'h3FF, 8'hFF, 12'h000, "lg wr top");
        // R3: upper address bits ignored, including for the write guard (R7)
        run_op(8'h0D, 1'b0, 10'h3E7, 8'h00, good_rx(8'h0D, 10'h007, 8'h5A, 1'b0), "R3 mask rd");
        run_op(8'h0D, 1'b1, 10'h3E3, 8'hA5, 12'h000, "R7 masked refuse");
        run_op(8'h1D, 1'b1, 10'h302, 8'h11, 12'h000, "R7 masked refuse med");
        run_op(8'h1D, 1'b1, 10'h305, 8'h11, 12'h000, "R7 boundary 5");
        // R2: unknown card types
        run_op(8'h00, 1'b0, 10'h010, 8'h00, 12'hABC, "R2 type 00");
        run_op(8'h0C, 1'b1, 10'h010, 8'h33, 12'h000, "R2 type 0C");
        run_op(8'h2D, 1'b0, 10'h010, 8'h00, 12'h123, "R2 type 2D");
        run_op(8'hFF, 1'b1, 10'h001, 8'h33, 12'h000, "R2 type FF");

        // R9: start and input changes during a busy operation are ignored
        begin
            int elat, el, lat, extra;
            logic [22:0] ew;
            logic [7:0] eb;
            bit ec, et, ea;
            expect_of(8'h1D, 1'b1, 10'h055, 8'hC3, 12'h000, elat, ew, el, eb, ec, et, ea);
            card_type = 8'h1D; op_write = 1'b1; addr = 10'h055; wr_data = 8'hC3; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            lat = 0;
            while (!done && lat < 40) begin
                @(posedge clk); #1;
                lat++;
                if (lat == 3) begin
                    card_type = 8'h3D; op_write = 1'b0; addr = 10'h2AA; wr_data = 8'h00;
                    rx_frame = 12'hFFF; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
            end
            start = 1'b0;
            chk(lat == elat, "R9 latency unchanged", lat, elat);
            chk(cmd_word == ew, "R9 frame unchanged", cmd_word, ew);
            chk(cmd_len == 5'(el), "R9 len unchanged", cmd_len, el);
            extra = 0;
            for (int i = 0; i < 30; i++) begin
                @(posedge clk); #1;
                if (done) extra++;
            end
            chk(extra == 0, "R9 no second completion", extra, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule